// File: doc/BRIEF.md
# Periodic Clock-Pulse Trimming Unit

This block derives a one-second tick from a 32.768 kHz reference and corrects for a crystal that runs fast or slow. Every clock cycle is one reference pulse. A prescaler counts `PRESC_NOM` pulses per second. Seconds are grouped into correction windows of `WIN_SHORT` (20) or `WIN_LONG` (60) seconds. In the first second of each window, the prescaler terminal count is moved up or down by an even number of pulses. Every later second of the window is nominal.

Software writes one 8-bit trim word. Bit 7 selects the long window. Bit 6 selects removal of pulses; when it is clear, pulses are inserted. Bits 5:0 are the amount code. A write is not used at once. It is held as pending, and `busy` reads high until the next window boundary. At that boundary the pending word becomes the applied word, and that applied word sets both the length of the new window and its correction. The `trim_off` input lets the timekeeping mode switch correction off without changing the stored word.

The control path is a two-state machine with states CF_IDLE and CF_PENDING. Transition W_ACCEPT (CF_IDLE to CF_PENDING) fires on a write while idle. Transition W_APPLY (CF_PENDING to CF_IDLE) fires at a window boundary. The sequencer is a two-state machine with states ST_NOMINAL and ST_TRIM. Transition T_ENTER (ST_NOMINAL to ST_TRIM) fires on the last tick of a window. Transition T_LEAVE (ST_TRIM to ST_NOMINAL) fires on the tick that ends the correction second, unless that tick is also the last of a window.

Top module: `pulse_trim_top`

## Requirements
- R1: After reset `busy` is 0 and `act_cfg` is 0. The first window is `WIN_SHORT` seconds long. The first `sec_tick` comes on the `PRESC_NOM`-th cycle after reset is released.
- R2: `sec_tick` is a single-cycle pulse. Every second except the first second of a window lasts exactly `PRESC_NOM` cycles.
- R3: `win_tick` is high only together with `sec_tick`, on the last tick of a window. A window lasts `WIN_LONG` seconds when bit 7 of `act_cfg` is 1, and `WIN_SHORT` seconds when bit 7 is 0.
- R4: Insertion applies when bit 6 of `act_cfg` is 0 and the code v in bits 5:0 is 2 to 63. The first second of the window then lasts `PRESC_NOM + 2*(v-1)` cycles.
- R5: Removal applies when bit 6 is 1 and v is 2 to 63. The first second then lasts `PRESC_NOM - 2*((~v & 63) + 1)` cycles, which removes 2 to 124 pulses.
- R6: Codes 0 and 1 give no correction in either direction. The first second is then `PRESC_NOM` cycles.
- R7: A write while `busy` is 0 raises `busy` on the next cycle. The written word appears on `act_cfg`, and `busy` falls, in the cycle after the next `win_tick`. `act_cfg` changes at no other time.
- R8: A write while `busy` is 1 is ignored. The word applied at the next boundary is the first write.
- R9: When `trim_off` is 1 during the boundary cycle, the following first second is nominal. The pending word is still applied to `act_cfg`.
- R10: The applied correction repeats in the first second of every window until a new word is applied. It affects only that one second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz reference, one pulse per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| trim_off | input | 1 | 1 disables correction (other timekeeping mode) |
| cfg_wr | input | 1 | Write strobe for the trim word |
| cfg_wdata | input | 8 | Trim word: [7] long window, [6] remove, [5:0] code |
| busy | output | 1 | A written word is waiting for the next boundary |
| act_cfg | output | 8 | Trim word currently applied |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| win_tick | output | 1 | One-cycle pulse at the end of each window |

## Verification
On every cycle the assertions check the handshake rules, the timing rules and the bounds:
- `busy` rises after an accepted write and falls only right after `win_tick`.
- `act_cfg` moves only at a boundary.
- The ticks are single-cycle, and `win_tick` never comes without `sec_tick`.
- Each second that is not the first of its window is exactly nominal, and each first second stays within the 124-pulse range.

Only the bench scenarios can show the exact decoded amount for each code and direction, the choice of window length, and the ignored second write. They also cover the `trim_off` override and the repeat of a correction across windows, by measuring tick spacing against values worked out from the requirements.

// File: rtl/pulse_trim_pkg.sv
package pulse_trim_pkg;

    localparam int CFG_W   = 8;
    localparam int CODE_W  = 6;

    // Applied/pending trim word; bit order is what the window select and
    // the direction decode rely on.
    typedef struct packed {
        logic              win_long;   // [7]
        logic              sub;        // [6]
        logic [CODE_W-1:0] code;       // [5:0]
    } trim_cfg_t;

    typedef enum logic [0:0] {
        CF_IDLE,
        CF_PENDING
    } cfg_state_t;

    typedef enum logic [0:0] {
        ST_NOMINAL,
        ST_TRIM
    } seq_state_t;

endpackage

// File: rtl/pulse_trim_decode.sv
module pulse_trim_decode #(
    parameter int CODE_W = 6,
    parameter int DW     = CODE_W + 3
) (
    input  logic                 sub,
    input  logic [CODE_W-1:0]    code,
    input  logic                 inhibit,
    output logic signed [DW-1:0] delta
);

    localparam int SW = CODE_W + 1;

    logic [SW-1:0] steps_add;
    logic [SW-1:0] steps_sub;
    logic [SW-1:0] steps;
    logic [DW-1:0] mag;

    always_comb begin
        // insertion: code is biased by one step
        steps_add = {1'b0, code} - SW'(1);
        // removal: inverted code plus one
        steps_sub = {1'b0, ~code} + SW'(1);
        if (inhibit || (code < CODE_W'(2))) begin
            steps = '0;
        end else if (sub) begin
            steps = steps_sub;
        end else begin
            steps = steps_add;
        end
        // each step is two reference pulses
        mag   = DW'(steps) << 1;
        delta = sub ? -$signed(mag) : $signed(mag);
    end

endmodule

// File: rtl/pulse_trim_cfg.sv
module pulse_trim_cfg
    import pulse_trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  trim_cfg_t wdata,
    input  logic      boundary,
    output logic      busy,
    output trim_cfg_t act,
    output trim_cfg_t act_next
);

    cfg_state_t state, state_nx;
    trim_cfg_t  pend, pend_nx;
    trim_cfg_t  act_q, act_nx;

    // state and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CF_IDLE;
            pend  <= '0;
            act_q <= '0;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
            act_q <= act_nx;
        end
    end

    // transitions W_ACCEPT and W_APPLY
    always_comb begin
        state_nx = state;
        pend_nx  = pend;
        act_nx   = act_q;
        unique case (state)
            CF_IDLE: begin
                if (wr) begin
                    pend_nx  = wdata;
                    state_nx = CF_PENDING;
                end
            end
            CF_PENDING: begin
                if (boundary) begin
                    act_nx   = pend;
                    state_nx = CF_IDLE;
                end
            end
            default: state_nx = CF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state == CF_PENDING);
        act      = act_q;
        act_next = act_nx;
    end

endmodule

// File: rtl/pulse_trim_seq.sv
module pulse_trim_seq
    import pulse_trim_pkg::*;
#(
    parameter int PRESC_NOM = 32768,
    parameter int WIN_SHORT = 20,
    parameter int WIN_LONG  = 60,
    parameter int DW        = 9,
    parameter int CNT_W     = 17,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_long,
    input  logic                 win_long_next,
    input  logic signed [DW-1:0] delta_next,
    output logic                 sec_tick,
    output logic                 win_tick
);

    localparam logic [CNT_W-1:0] NOM_M1 = CNT_W'(PRESC_NOM - 1);
    localparam logic [IDX_W-1:0] LAST_S = IDX_W'(WIN_SHORT - 1);
    localparam logic [IDX_W-1:0] LAST_L = IDX_W'(WIN_LONG - 1);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] pcnt, pcnt_nx;
    logic [CNT_W-1:0] term, term_nx;
    logic [IDX_W-1:0] sec_idx, idx_nx;
    logic [CNT_W-1:0] trim_term;
    logic [CNT_W-1:0] delta_ext;
    logic             tick;
    logic             last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_NOMINAL;
            pcnt    <= '0;
            term    <= NOM_M1;
            sec_idx <= '0;
        end else begin
            state   <= state_nx;
            pcnt    <= pcnt_nx;
            term    <= term_nx;
            sec_idx <= idx_nx;
        end
    end

    // outputs
    always_comb begin
        tick     = (pcnt == term);
        last     = (sec_idx == (win_long ? LAST_L : LAST_S));
        sec_tick = tick;
        win_tick = tick && last;
    end

    // transitions T_ENTER and T_LEAVE, plus counters
    always_comb begin
        delta_ext = {{(CNT_W - DW){delta_next[DW-1]}}, delta_next};
        trim_term = NOM_M1 + delta_ext;
        state_nx  = state;
        unique case (state)
            ST_NOMINAL: if (tick && last) state_nx = ST_TRIM;
            ST_TRIM:    if (tick)         state_nx = last ? ST_TRIM : ST_NOMINAL;
            default:                      state_nx = ST_NOMINAL;
        endcase
        pcnt_nx = tick ? '0 : pcnt + CNT_W'(1);
        term_nx = term;
        idx_nx  = sec_idx;
        if (tick) begin
            term_nx = (state_nx == ST_TRIM) ? trim_term : NOM_M1;
            idx_nx  = last ? '0 : sec_idx + IDX_W'(1);
        end
    end

    // window select of the word applied at the boundary is taken from
    // win_long on the following cycle; the next value is unused here.
    logic unused_next;
    assign unused_next = win_long_next;

endmodule

// File: rtl/pulse_trim_top.sv
module pulse_trim_top
    import pulse_trim_pkg::*;
#(
    parameter int PRESC_NOM = 32768,
    parameter int WIN_SHORT = 20,
    parameter int WIN_LONG  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trim_off,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             busy,
    output logic [CFG_W-1:0] act_cfg,
    output logic             sec_tick,
    output logic             win_tick
);

    localparam int DW     = CODE_W + 3;
    localparam int CNT_W  = $clog2(PRESC_NOM + (2 ** (CODE_W + 1))) + 1;
    localparam int WIN_MX = (WIN_LONG > WIN_SHORT) ? WIN_LONG : WIN_SHORT;
    localparam int IDX_W  = (WIN_MX < 2) ? 1 : $clog2(WIN_MX);

    trim_cfg_t             act, act_next;
    logic signed [DW-1:0]  delta_next;

    pulse_trim_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (trim_cfg_t'(cfg_wdata)),
        .boundary (win_tick),
        .busy     (busy),
        .act      (act),
        .act_next (act_next)
    );

    pulse_trim_decode #(
        .CODE_W (CODE_W),
        .DW     (DW)
    ) u_dec (
        .sub     (act_next.sub),
        .code    (act_next.code),
        .inhibit (trim_off),
        .delta   (delta_next)
    );

    pulse_trim_seq #(
        .PRESC_NOM (PRESC_NOM),
        .WIN_SHORT (WIN_SHORT),
        .WIN_LONG  (WIN_LONG),
        .DW        (DW),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .win_long      (act.win_long),
        .win_long_next (act_next.win_long),
        .delta_next    (delta_next),
        .sec_tick      (sec_tick),
        .win_tick      (win_tick)
    );

    assign act_cfg = act;

endmodule

// File: rtl/pulse_trim_chk.sv
module pulse_trim_chk #(
    parameter int PRESC_NOM = 32768,
    parameter int CODE_W    = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       busy,
    input logic [7:0] act_cfg,
    input logic       sec_tick,
    input logic       win_tick
);

    localparam int MAXP = 2 * ((2 ** CODE_W) - 2);

    int   gap;
    logic after_win;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= 1;
            after_win <= 1'b0;
        end else if (sec_tick) begin
            gap       <= 1;
            after_win <= win_tick;
        end else begin
            gap       <= gap + 1;
        end
    end

    a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !busy) |=> busy);

    a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(win_tick));

    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !win_tick) |=> busy);

    a_r7_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> $past(win_tick));

    a_r3_win_with_sec: assert property (@(posedge clk) disable iff (!rst_n)
        win_tick |-> sec_tick);

    a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    a_r2_nominal_len: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !after_win) |-> (gap == PRESC_NOM));

    a_r10_trim_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && after_win) |->
        ((gap >= PRESC_NOM - MAXP) && (gap <= PRESC_NOM + MAXP)));

endmodule

bind pulse_trim_top pulse_trim_chk #(
    .PRESC_NOM (PRESC_NOM),
    .CODE_W    (CODE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .busy     (busy),
    .act_cfg  (act_cfg),
    .sec_tick (sec_tick),
    .win_tick (win_tick)
);

// File: tb/pulse_trim_top_test.sv
`timescale 1ns/1ps
module pulse_trim_top_test;

    localparam int NOM = 256;
    localparam int WS  = 2;
    localparam int WL  = 4;
    localparam int NV  = 10;

    // stimulus word and expected pulse shift of the first second
    localparam logic [7:0] VEC_CFG [NV] = '{
        8'h05, 8'h3F, 8'h00, 8'h01, 8'h42,
        8'h7F, 8'h82, 8'hF0, 8'h40, 8'h41
    };
    localparam int VEC_DELTA [NV] = '{
        8, 124, 0, 0, -124,
        -2, 2, -32, 0, 0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trim_off = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       busy;
    logic [7:0] act_cfg;
    logic       sec_tick;
    logic       win_tick;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pulse_trim_top #(
        .PRESC_NOM (NOM),
        .WIN_SHORT (WS),
        .WIN_LONG  (WL)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .trim_off  (trim_off),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .act_cfg   (act_cfg),
        .sec_tick  (sec_tick),
        .win_tick  (win_tick)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_wdata = v;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
        chk("R7 busy after write", int'(busy), 1);
    endtask

    // waits for the next boundary and measures the window that follows
    task automatic run_window(input logic [7:0] exp_act, input int exp_len,
                              input int exp_w, input string len_tag);
        int cnt;
        int w;
        int g;
        do @(negedge clk); while (!win_tick);
        @(negedge clk);
        cnt = 1;
        chk("R7 act_cfg after boundary", int'(act_cfg), int'(exp_act));
        chk("R7 busy cleared at boundary", int'(busy), 0);
        while (!sec_tick) begin
            @(negedge clk);
            cnt++;
        end
        chk(len_tag, cnt, exp_len);
        w = 1;
        while (!win_tick) begin
            g = 0;
            do begin
                @(negedge clk);
                g++;
            end while (!sec_tick);
            chk("R2 nominal second", g, NOM);
            w++;
        end
        chk("R3 window length", w, exp_w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int cnt;
        int w;
        string tag;

        // reset state (R1)
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 act_cfg in reset", int'(act_cfg), 0);
        rst_n = 1'b1;
        cnt = 1;
        while (!sec_tick) begin
            @(negedge clk);
            cnt++;
        end
        chk("R1 first second", cnt, NOM);
        w = 1;
        while (!win_tick) begin
            do @(negedge clk); while (!sec_tick);
            w++;
        end
        chk("R1 first window short", w, WS);

        // table walk (R3, R4, R5, R6, R7)
        for (int i = 0; i < NV; i++) begin
            if (VEC_CFG[i][5:0] < 6'd2)  tag = "R6 no correction";
            else if (VEC_CFG[i][6])      tag = "R5 removal length";
            else                         tag = "R4 insertion length";
            write_cfg(VEC_CFG[i]);
            run_window(VEC_CFG[i], NOM + VEC_DELTA[i],
                       VEC_CFG[i][7] ? WL : WS, tag);
        end

        // second write while busy is ignored (R8)
        write_cfg(8'h09);
        cfg_wdata = 8'h47;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
        chk("R8 busy held", int'(busy), 1);
        run_window(8'h09, NOM + 16, WS, "R8 first write kept");

        // correction switched off (R9), then repeated correction (R10)
        trim_off = 1'b1;
        write_cfg(8'h3F);
        run_window(8'h3F, NOM, WS, "R9 trim_off gives nominal");
        trim_off = 1'b0;
        run_window(8'h3F, NOM + 124, WS, "R10 correction repeats");

        // reset during a pending write (R1)
        write_cfg(8'h05);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 act_cfg after reset", int'(act_cfg), 0);
        rst_n = 1'b1;
        cnt = 1;
        while (!sec_tick) begin
            @(negedge clk);
            cnt++;
        end
        chk("R1 second after reset", cnt, NOM);

        finish_run();
    end

endmodule